// File: doc/BRIEF.md
# Smart-card UART with parity-error signalling

This block is a half-duplex asynchronous transceiver for a smart-card or SIM link. The transmit output and the receive input sit on one shared wire with an external pull-up. The block only ever pulls that wire low; when it is not pulling, the wire floats high. A frame is a low start bit, eight data bits sent least significant bit first, an even-parity bit and a high stop bit. Each bit lasts `baud_div` clock cycles.

When a received frame fails the parity check and error signalling is enabled, the receiver pulls the shared wire low from the middle of the stop bit. This tells the far end that the frame was corrupt. The low drive lasts for at least one bit period. It continues until software reads the receive buffer. On the transmit side, a one-cycle completion pulse marks the end of the stop bit. At that moment software can sample the wire and find out whether the card is signalling an error back. The transmitter stays busy for one further guard bit. While it is busy, the receiver ignores the wire, so the block's own echo is never taken as a received frame.

Top module: `sc_uart`

## Requirements
- R1: A write accepted on `tx_wr` sends a frame on the wire. The frame is start bit 0, then data bits 0 to 7 (LSB first), then the even parity of the data byte, then stop bit 1. Each bit lasts `baud_div` cycles and the start bit begins on the clock edge that accepts the write.
- R2: `tx_done` is high for exactly one cycle, on the edge that ends the stop bit. `tx_busy` stays 1 for one further bit period (the guard bit). A `tx_wr` seen while `tx_busy` is 1 is discarded.
- R3: The receiver samples each bit at mid-period after a falling start edge. At the middle of the stop bit it loads `rx_data` and sets `rx_full`.
- R4: When the received data bits and the parity bit together contain an odd number of ones, `rx_par_err` is set along with `rx_full`; otherwise it is cleared.
- R5: When a parity error is received while `err_sig_en` is 1, `line_drive_low` pulls the wire low from the middle of the stop bit. The drive lasts at least one bit period and, in addition, until the buffer is read.
- R6: While `err_sig_en` is 0, a parity error never drives the wire.
- R7: A pulse on `rx_rd` clears `rx_full` and `rx_par_err`. If the minimum hold of R5 has already elapsed, the same clock edge also releases the error drive.
- R8: A start edge whose wire is high again at mid-bit is rejected and produces no frame.
- R9: While `tx_busy` is 1 the receiver ignores the wire, so the transmitted frame sets neither `rx_full` nor `rx_par_err`.
- R10: After reset the wire is released, and `tx_busy`, `tx_done`, `rx_full` and `rx_par_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Bit period in clock cycles (at least 8) |
| err_sig_en | input | 1 | Enables the parity-error low drive |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| line_in | input | 1 | Level of the shared wire |
| line_drive_low | output | 1 | 1 pulls the shared wire low; 0 releases it |
| tx_busy | output | 1 | Transmitter is sending a frame or its guard bit |
| tx_done | output | 1 | One-cycle pulse at the end of the stop bit |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_par_err | output | 1 | Parity error in the last received byte |

## Verification
The bench builds the block with an 8-bit divider field. It runs traffic at a bit period of 16 cycles and then at 9 cycles. At 9 cycles the odd period checks that the half-period sampling point and the synchronizer delay stay inside each bit. At 16 cycles there is room to read the buffer before the minimum error hold expires, so both ways the error drive can end are exercised. A modelled card shares the wire through a wired-AND. It sends good and bad-parity frames, sends a short glitch, and pulls the wire low during the block's own stop bit, so the completion-time line sample is observed.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int RX_BITS    = DATA_BITS + 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_SHIFT = 2'd2
  } rx_state_t;
endpackage

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             wr,
  input  logic [7:0]       data,
  output logic             tx_bit,
  output logic             busy,
  output logic             done
);
  localparam int IDX_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      bit_idx;
  logic [DIV_W-1:0]      cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      bit_idx <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      tx_bit  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (wr) begin
          shreg   <= {1'b1, ^data, data, 1'b0};
          busy    <= 1'b1;
          cnt     <= '0;
          bit_idx <= '0;
          tx_bit  <= 1'b0;
        end
      end else if (cnt == baud_div - 1'b1) begin
        cnt     <= '0;
        bit_idx <= bit_idx + 1'b1;
        shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
        tx_bit  <= shreg[1];
        if (bit_idx == IDX_W'(FRAME_BITS - 1)) done <= 1'b1;
        if (bit_idx == IDX_W'(FRAME_BITS)) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_bit);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             line_s,
  input  logic             ignore,
  input  logic             err_en,
  input  logic             rd,
  output logic [7:0]       data,
  output logic             full,
  output logic             par_err,
  output logic             err_drive
);
  localparam int IDX_W = $clog2(RX_BITS + 1);

  rx_state_t            state;
  logic [DIV_W-1:0]     cnt;
  logic [DIV_W-1:0]     hold_cnt;
  logic                 hold_done;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS:0]   sh;
  logic                 perr;

  assign perr = ^sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      hold_cnt  <= '0;
      hold_done <= 1'b0;
      idx       <= '0;
      sh        <= '0;
      data      <= '0;
      full      <= 1'b0;
      par_err   <= 1'b0;
      err_drive <= 1'b0;
    end else begin
      if (rd) begin
        full    <= 1'b0;
        par_err <= 1'b0;
      end
      if (err_drive) begin
        if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
        if (hold_cnt == baud_div - 1'b1) hold_done <= 1'b1;
        if (hold_done && (rd || !par_err)) err_drive <= 1'b0;
      end
      if (ignore) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: if (!line_s && !err_drive) begin
            state <= RX_START;
            cnt   <= '0;
          end
          RX_START: if (cnt == (baud_div >> 1)) begin
            cnt   <= '0;
            idx   <= '0;
            state <= line_s ? RX_IDLE : RX_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_SHIFT: if (cnt == baud_div - 1'b1) begin
            cnt <= '0;
            if (idx == IDX_W'(RX_BITS - 1)) begin
              data    <= sh[DATA_BITS-1:0];
              full    <= 1'b1;
              par_err <= perr;
              if (perr && err_en) begin
                err_drive <= 1'b1;
                hold_cnt  <= '0;
                hold_done <= 1'b0;
              end
              state <= RX_IDLE;
            end else begin
              sh  <= {line_s, sh[DATA_BITS:1]};
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  a_r5_drive_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_drive) |-> (par_err && err_en));
  a_r5_hold_min: assert property (@(posedge clk) disable iff (rst)
    (err_drive && !hold_done) |=> err_drive);
  a_r7_read_release: assert property (@(posedge clk) disable iff (rst)
    (err_drive && hold_done && rd) |=> !err_drive);
endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             err_sig_en,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             rx_rd,
  input  logic             line_in,
  output logic             line_drive_low,
  output logic             tx_busy,
  output logic             tx_done,
  output logic [7:0]       rx_data,
  output logic             rx_full,
  output logic             rx_par_err
);
  logic [1:0] sync_q;
  logic       tx_bit;
  logic       err_drive;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], line_in};
  end

  sc_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .baud_div(baud_div), .wr(tx_wr), .data(tx_data),
    .tx_bit(tx_bit), .busy(tx_busy), .done(tx_done)
  );

  sc_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .baud_div(baud_div), .line_s(sync_q[1]),
    .ignore(tx_busy), .err_en(err_sig_en), .rd(rx_rd),
    .data(rx_data), .full(rx_full), .par_err(rx_par_err), .err_drive(err_drive)
  );

  // open drain: the released level is the AND of tx data and no error
  assign line_drive_low = !(tx_bit && !err_drive);

  a_r9_no_echo: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && $past(tx_busy)) |-> !$rose(rx_full));
  a_r6_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    (!err_sig_en && !tx_busy && !$past(err_sig_en) && !$past(line_drive_low))
      |-> !line_drive_low);
endmodule

// File: tb/tb_sc_uart.sv
module tb_sc_uart;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [DIV_W-1:0] baud_div;
  logic err_sig_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, card_drive = 1'b0;
  logic [7:0] tx_data = '0;
  logic line_in, line_drive_low, tx_busy, tx_done, rx_full, rx_par_err;
  logic [7:0] rx_data;
  int N = 16;
  int vectors = 0, miscompares = 0;
  logic [8:0] expq[$];
  logic full_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign baud_div = DIV_W'(N);
  assign line_in = !line_drive_low && !card_drive;

  sc_uart #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .baud_div(baud_div), .err_sig_en(err_sig_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .line_in(line_in),
    .line_drive_low(line_drive_low), .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_data(rx_data), .rx_full(rx_full), .rx_par_err(rx_par_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R3/R4 received byte and parity flag
  always @(negedge clk) begin
    if (!rst && rx_full && !full_q) begin
      if (expq.size() == 0) chk(0, "R3 unexpected frame", rx_data, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk(rx_data == e[7:0], "R3 data", rx_data, e[7:0]);
        chk(rx_par_err == e[8], "R4 parity flag", rx_par_err, e[8]);
      end
    end
    full_q = rx_full;
  end

  task automatic tx_send(input logic [7:0] d, input bit card_err, input bit poke);
    logic [10:0] fr;
    fr = {1'b1, ^d, d, 1'b0};
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(posedge clk); #1 tx_wr = 1'b0;
    for (int k = 0; k < 11; k++) begin
      repeat (N/2) @(posedge clk);
      #1 chk(line_in == fr[k], "R1 frame bit", line_in, fr[k]);
      if (k == 10) begin
        chk(tx_done == 0, "R2 no early done", tx_done, 0);
        card_drive = card_err;
      end
      if (poke && k == 3) begin
        tx_wr = 1'b1; tx_data = ~d;
        @(posedge clk); #1 tx_wr = 1'b0;
        repeat (N - N/2 - 1) @(posedge clk);
      end else repeat (N - N/2) @(posedge clk);
    end
    #1 chk(tx_done == 1, "R2 done at stop end", tx_done, 1);
    chk(line_in == !card_err, "R2 line at done", line_in, !card_err);
    chk(tx_busy == 1, "R2 guard busy", tx_busy, 1);
    repeat (N/2) @(posedge clk);
    #1 card_drive = 1'b0;
    repeat (N - N/2) @(posedge clk);
    #1 chk(tx_busy == 0, "R2 busy end", tx_busy, 0);
    chk(rx_full == 0, "R9 no echo full", rx_full, 0);
    repeat (3) @(posedge clk);
    #1 chk(tx_busy == 0, "R2 busy write dropped", tx_busy, 0);
  endtask

  task automatic card_send(input logic [7:0] d, input bit bad, input bit qread);
    logic [10:0] fr;
    bit drv;
    fr = {1'b1, (^d) ^ bad, d, 1'b0};
    drv = bad && err_sig_en;
    expq.push_back({bad, d});
    @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      card_drive = !fr[k];
      repeat (N) @(negedge clk);
    end
    card_drive = 1'b0;
    repeat (2) @(negedge clk);
    chk(line_in == !drv, drv ? "R5 error drive" : "R6 no drive", line_in, !drv);
    chk(rx_full == 1, "R3 full", rx_full, 1);
    chk(rx_par_err == bad, "R4 flag", rx_par_err, bad);
    if (qread && drv) begin
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      chk(rx_full == 0, "R7 full cleared", rx_full, 0);
      chk(line_in == 0, "R5 minimum hold", line_in, 0);
      repeat (N) @(negedge clk);
      chk(line_in == 1, "R7 release after hold", line_in, 1);
    end else begin
      repeat (2*N) @(negedge clk);
      chk(line_in == !drv, "R5 held until read", line_in, !drv);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      chk(rx_full == 0, "R7 full cleared", rx_full, 0);
      chk(rx_par_err == 0, "R7 flag cleared", rx_par_err, 0);
      chk(line_in == 1, "R7 released on read", line_in, 1);
    end
    repeat (N) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(line_in == 1, "R10 line", line_in, 1);
    chk(tx_busy == 0, "R10 busy", tx_busy, 0);
    chk(tx_done == 0, "R10 done", tx_done, 0);
    chk(rx_full == 0 && rx_par_err == 0, "R10 rx flags", {rx_full, rx_par_err}, 0);

    N = 16; err_sig_en = 1'b1;
    tx_send(8'hA5, 1'b0, 1'b1);
    tx_send(8'h3C, 1'b1, 1'b0);
    card_send(8'h5A, 1'b0, 1'b0);
    card_send(8'h81, 1'b1, 1'b0);
    card_send(8'hF0, 1'b1, 1'b1);
    // R8 glitch rejection
    @(negedge clk); card_drive = 1'b1;
    repeat (2) @(negedge clk); card_drive = 1'b0;
    repeat (12*N) @(negedge clk);
    chk(rx_full == 0, "R8 glitch rejected", rx_full, 0);

    N = 9;
    card_send(8'h6E, 1'b0, 1'b0);
    err_sig_en = 1'b0;
    card_send(8'h17, 1'b1, 1'b0);
    tx_send(8'hC3, 1'b0, 1'b0);
    chk(expq.size() == 0, "R3 all frames seen", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule